// File: doc/BRIEF.md
# Two-Class Prioritised Interrupt Controller

This block gathers fifteen interrupt lines, numbered 1 to 15, and turns them into a single 4-bit request level for one processor. A rising edge on a line latches a pending bit. Software can also raise any line on purpose through a per-processor force word. A class word splits the lines into an urgent class and a normal class. A per-processor enable word gates which lines may reach the processor. Any request in the urgent class hides every request in the normal class. Within a class, the line with the highest number is presented.

Software can mark lines for fan-out. An edge on a marked line then sets that line's bit in every processor's force word and leaves the pending word alone. Only processor 0 drives the request output. The enable, force and 4-bit extension words of the other processors are stored and can be read back. When the processor takes an interrupt it returns the line number on the acknowledge port. This clears that line's bit in the pending word and in processor 0's force word.

Registers are reached through a plain 32-bit register port. Each access is one cycle wide. No ready signal exists, so there is no back-pressure: the block accepts every access in the cycle it is presented. A write takes effect at that clock edge. Read data is combinational while the access is held.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every stored word reads 0 and `irl` is 0.
- R2: A 0-to-1 change on `irq_in[n]` (n in 1..15) whose fan-out bit is 0 sets bit n of the pending word (offset 0x04) at the next clock edge. A line held high does not set the bit again once it has been cleared.
- R3: A 0-to-1 change on line n whose fan-out bit (offset 0x14) is 1 sets bit n in the force word of every processor and leaves the pending word unchanged.
- R4: A write to offset 0x0C clears each pending bit that is 1 in the written value. Bit 0 of the value has no effect.
- R5: A write to the force word of processor c (offset 0x80 + 4c) produces (old OR wdata[15:1]) AND NOT wdata[31:17], with the bit positions of the clear field shifted down by 16. Other processors' force words are unchanged.
- R6: A write to offset 0x08 replaces processor 0's force word with wdata[15:1]. A read of 0x08 returns that word.
- R7: The request set is (pending OR force0) AND enable0, where enable0 is at offset 0x40. If any requested line has its class bit (offset 0x00) set to 1, `irl` is the highest such line. Otherwise `irl` is the highest requested line. With no request, `irl` is 0. `irl` follows the stored words without a clock delay.
- R8: `ack_valid` with `ack_num` = n clears bit n of the pending word and of processor 0's force word at the next edge. Other processors' force words keep the bit.
- R9: If an edge on line n lands in the same cycle as a clear write or an acknowledge for n, bit n ends up set.
- R10: The class, enable, fan-out and force words keep only bits 15:1, and the extension words (offset 0xC0 + 4c) keep only bits 3:0. The word at 0x10 always reads 0 and ignores writes. Writes to 0x04 are ignored. Unmapped offsets read 0.
- R11: Only accesses with `bus_be` = 4'hF are accepted. Other writes change nothing, and other reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Interrupt lines; bit 0 unused |
| bus_valid | input | 1 | Register access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the 256-byte window |
| bus_be | input | 4 | Byte enables; must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is held |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_num | input | 4 | Number of the acknowledged line |
| irl | output | 4 | Request level to processor 0; 0 = none |

## Verification
The embedded properties watch, on every cycle, these invariants:
- a captured edge always lands in the pending word;
- an acknowledge with no competing edge always clears its bit;
- bit 0 never becomes set;
- a partial-width write never disturbs the class or fan-out words;
- a nonzero `irl` always names an enabled, requested line;
- an urgent request always wins over normal ones.

Only the directed scenarios can show the following:
- the exact arithmetic of the combined set/clear force write;
- the fan-out into other processors' words;
- highest-number selection inside a class;
- field truncation on read-back;
- a new edge beating a clear in the same cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam logic [7:0] OFS_CLASS   = 8'h00;
  localparam logic [7:0] OFS_PEND    = 8'h04;
  localparam logic [7:0] OFS_FALIAS  = 8'h08;
  localparam logic [7:0] OFS_PCLR    = 8'h0C;
  localparam logic [7:0] OFS_MPSTAT  = 8'h10;
  localparam logic [7:0] OFS_FANOUT  = 8'h14;
  // bits 7:6 of the offset select the per-processor bank
  localparam logic [1:0] BANK_GLOBAL = 2'd0;
  localparam logic [1:0] BANK_ENABLE = 2'd1;
  localparam logic [1:0] BANK_FORCE  = 2'd2;
  localparam logic [1:0] BANK_EXT    = 2'd3;
  localparam logic [3:0] FULL_WORD   = 4'hF;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_in;
  end

  assign rise = lvl_in & ~lvl_q;
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  // highest set bit wins; bit 0 is never a line, so 0 means none
  always_comb begin
    idx = '0;
    for (int i = 1; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irqc_level_sel.sv
module irqc_level_sel #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  req,
  input  logic [W-1:0]  urgent,
  output logic [IW-1:0] irl
);
  logic [W-1:0]  hi_set, lo_set;
  logic [IW-1:0] hi_idx, lo_idx;

  assign hi_set = req & urgent;
  assign lo_set = req & ~urgent;

  irqc_prio_enc #(.W(W), .IW(IW)) u_hi (.vec(hi_set), .idx(hi_idx));
  irqc_prio_enc #(.W(W), .IW(IW)) u_lo (.vec(lo_set), .idx(lo_idx));

  assign irl = (|hi_set) ? hi_idx : lo_idx;

  // R7
  high_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & urgent) != '0) |-> (urgent[irl] && req[irl]));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_CPU = 16,
  parameter int LINES   = 16,
  parameter int EXT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         irq_in,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [7:0]               bus_addr,
  input  logic [3:0]               bus_be,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     ack_valid,
  input  logic [$clog2(LINES)-1:0] ack_num,
  output logic [$clog2(LINES)-1:0] irl
);
  localparam int IW    = $clog2(LINES);
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam logic [LINES-1:0] LMASK = {{(LINES-1){1'b1}}, 1'b0};

  logic [LINES-1:0] class_q, pend_q, fanout_q;
  logic [LINES-1:0] enable_q [NUM_CPU];
  logic [LINES-1:0] force_q  [NUM_CPU];
  logic [LINES-1:0] force_d  [NUM_CPU];
  logic [EXT_W-1:0] ext_q    [NUM_CPU];

  // ---------------- access decode ----------------
  logic       acc_ok, wr;
  logic [1:0] bank;
  logic [3:0] slot;
  logic       slot_ok;
  logic [CPU_W-1:0] sidx;

  assign acc_ok  = bus_valid && (bus_be == FULL_WORD);
  assign wr      = acc_ok && bus_write;
  assign bank    = bus_addr[7:6];
  assign slot    = bus_addr[5:2];
  assign slot_ok = (32'(slot) < NUM_CPU) && (bus_addr[1:0] == 2'b00);
  assign sidx    = CPU_W'(slot);

  logic wr_class, wr_alias, wr_pclr, wr_fanout, wr_en_bank, wr_f_bank, wr_x_bank;
  assign wr_class   = wr && bus_addr == OFS_CLASS;
  assign wr_alias   = wr && bus_addr == OFS_FALIAS;
  assign wr_pclr    = wr && bus_addr == OFS_PCLR;
  assign wr_fanout  = wr && bus_addr == OFS_FANOUT;
  assign wr_en_bank = wr && bank == BANK_ENABLE && slot_ok;
  assign wr_f_bank  = wr && bank == BANK_FORCE  && slot_ok;
  assign wr_x_bank  = wr && bank == BANK_EXT    && slot_ok;

  logic [LINES-1:0] set_bits, kill_bits, pclr_bits, ack_bits;
  assign set_bits  = bus_wdata[LINES-1:0] & LMASK;
  assign kill_bits = bus_wdata[16 +: LINES] & LMASK;
  assign pclr_bits = wr_pclr ? set_bits : '0;
  assign ack_bits  = ack_valid ? ((LINES'(1) << ack_num) & LMASK) : '0;

  // ---------------- event capture ----------------
  logic [LINES-1:0] rise_raw, rise, ev_pend, ev_fan;

  irqc_edge #(.W(LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_in(irq_in), .rise(rise_raw)
  );

  assign rise    = rise_raw & LMASK;
  assign ev_pend = rise & ~fanout_q;
  assign ev_fan  = rise & fanout_q;

  // ---------------- global words ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      class_q  <= '0;
      pend_q   <= '0;
      fanout_q <= '0;
    end else begin
      if (wr_class)  class_q  <= set_bits;
      if (wr_fanout) fanout_q <= set_bits;
      // new events are OR-ed last so they beat clears and acknowledges
      pend_q <= (pend_q & ~pclr_bits & ~ack_bits) | ev_pend;
    end
  end

  // ---------------- per-processor words ----------------
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic hit;
    assign hit = (32'(sidx) == c);

    always_comb begin
      force_d[c] = force_q[c];
      if (wr_f_bank && hit) force_d[c] = (force_d[c] | set_bits) & ~kill_bits;
      if (c == 0) begin
        if (wr_alias) force_d[c] = set_bits;
        force_d[c] = force_d[c] & ~ack_bits;
      end
      force_d[c] = force_d[c] | ev_fan;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        enable_q[c] <= '0;
        force_q[c]  <= '0;
        ext_q[c]    <= '0;
      end else begin
        force_q[c] <= force_d[c];
        if (wr_en_bank && hit) enable_q[c] <= set_bits;
        if (wr_x_bank && hit)  ext_q[c]    <= bus_wdata[EXT_W-1:0];
      end
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (acc_ok && !bus_write) begin
      if (bank == BANK_GLOBAL) begin
        case (bus_addr)
          OFS_CLASS:  bus_rdata = 32'(class_q);
          OFS_PEND:   bus_rdata = 32'(pend_q);
          OFS_FALIAS: bus_rdata = 32'(force_q[0]);
          OFS_FANOUT: bus_rdata = 32'(fanout_q);
          default:    bus_rdata = '0;
        endcase
      end else if (slot_ok) begin
        case (bank)
          BANK_ENABLE: bus_rdata = 32'(enable_q[sidx]);
          BANK_FORCE:  bus_rdata = 32'(force_q[sidx]);
          default:     bus_rdata = 32'(ext_q[sidx]);
        endcase
      end
    end
  end

  // ---------------- request output ----------------
  logic [LINES-1:0] req0;
  assign req0 = (pend_q | force_q[0]) & enable_q[0];

  irqc_level_sel #(.W(LINES), .IW(IW)) u_sel (
    .clk(clk), .rst_n(rst_n), .req(req0), .urgent(class_q), .irl(irl)
  );

  // ---------------- assertions ----------------
  // R2
  pend_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pend != '0) |=> ((pend_q & $past(ev_pend)) == $past(ev_pend)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_num != '0 && !rise[ack_num])
      |=> (!pend_q[$past(ack_num)] && !force_q[0][$past(ack_num)]));

  // R7
  irl_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irl != '0) |-> (enable_q[0][irl] && (pend_q[irl] || force_q[0][irl])));

  // R10
  no_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0] && !force_q[0][0] && !class_q[0]);

  // R11
  partial_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_be != FULL_WORD)
      |=> ($stable(class_q) && $stable(fanout_q) && $stable(enable_q[0])));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_num = '0;
  logic [3:0]  irl;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_num(ack_num), .irl(irl)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
    #1 chk(tag, bus_rdata, exp);
    bus_valid = 1'b0;
  endtask

  task automatic irl_chk(string tag, logic [3:0] exp);
    @(negedge clk);
    #1 chk(tag, {28'd0, irl}, {28'd0, exp});
  endtask

  task automatic pulse(logic [15:0] lines);
    @(negedge clk); irq_in = lines;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic ack(logic [3:0] n);
    @(negedge clk); ack_valid = 1'b1; ack_num = n;
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 class", 8'h00, 0);
    rd_chk("R1 pending", 8'h04, 0);
    rd_chk("R1 force0", 8'h08, 0);
    rd_chk("R1 fanout", 8'h14, 0);
    rd_chk("R1 enable0", 8'h40, 0);
    irl_chk("R1 irl", 0);
  endtask

  task automatic t_pending;
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R10 enable width", 8'h40, 32'h0000_FFFE);
    @(negedge clk); irq_in[5] = 1'b1;
    rd_chk("R2 edge latched", 8'h04, 32'h20);
    irl_chk("R7 single line", 5);
    wr(8'h0C, 32'h0000_FFFF);
    rd_chk("R4 clear", 8'h04, 0);
    rd_chk("R2 held level no re-trigger", 8'h04, 0);
    @(negedge clk); irq_in[5] = 1'b0;
  endtask

  task automatic t_priority;
    pulse(16'h0208);
    rd_chk("R2 two lines", 8'h04, 32'h208);
    wr(8'h00, 32'h8);
    irl_chk("R7 urgent low line wins", 3);
    wr(8'h00, 32'h0);
    irl_chk("R7 highest number", 9);
    wr(8'h40, 32'hFDFE);
    irl_chk("R7 enable gates line 9", 3);
    wr(8'h40, 32'hFFFE);
    wr(8'h0C, 32'h208);
    irl_chk("R7 none", 0);
  endtask

  task automatic t_force;
    wr(8'h80, 32'h0000_0006);
    rd_chk("R5 set", 8'h08, 32'h6);
    wr(8'h80, 32'h0002_0010);
    rd_chk("R5 set and clear", 8'h80, 32'h14);
    irl_chk("R7 force path", 4);
    wr(8'h8C, 32'h0000_00F0);
    rd_chk("R5 cpu3", 8'h8C, 32'hF0);
    rd_chk("R5 cpu0 untouched", 8'h08, 32'h14);
    wr(8'h08, 32'hFFFF_8001);
    rd_chk("R6 alias replace", 8'h08, 32'h8000);
    irl_chk("R7 line 15", 15);
    wr(8'h08, 32'h0);
    wr(8'h8C, 32'hFFFF_0000);
    rd_chk("R5 clear all", 8'h8C, 0);
  endtask

  task automatic t_fanout;
    wr(8'h14, 32'h0000_0081);
    rd_chk("R10 fanout width", 8'h14, 32'h80);
    pulse(16'h0080);
    rd_chk("R3 pending untouched", 8'h04, 0);
    rd_chk("R3 force0", 8'h08, 32'h80);
    rd_chk("R3 force cpu5", 8'h94, 32'h80);
    irl_chk("R3 request", 7);
    ack(4'd7);
    rd_chk("R8 force0 cleared", 8'h08, 0);
    rd_chk("R8 cpu5 kept", 8'h94, 32'h80);
    irl_chk("R8 irl idle", 0);
    wr(8'h94, 32'h0080_0000);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_ack;
    pulse(16'h0010);
    rd_chk("R8 before", 8'h04, 32'h10);
    ack(4'd4);
    rd_chk("R8 pending cleared", 8'h04, 0);
  endtask

  task automatic t_race;
    pulse(16'h0040);
    @(negedge clk);
    irq_in[6] = 1'b1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h40; bus_be = 4'hF;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; irq_in[6] = 1'b0;
    rd_chk("R9 event beats clear", 8'h04, 32'h40);
    @(negedge clk);
    irq_in[6] = 1'b1; ack_valid = 1'b1; ack_num = 4'd6;
    @(negedge clk);
    irq_in[6] = 1'b0; ack_valid = 1'b0;
    rd_chk("R9 event beats ack", 8'h04, 32'h40);
    wr(8'h0C, 32'h40);
  endtask

  task automatic t_fields;
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R10 class width", 8'h00, 32'hFFFE);
    wr(8'h00, 32'h0);
    wr(8'hC4, 32'hFFFF_FFFF);
    rd_chk("R10 ext width", 8'hC4, 32'hF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk("R10 mp status zero", 8'h10, 0);
    wr(8'h04, 32'hFFFF);
    rd_chk("R10 pending read-only", 8'h04, 0);
    rd_chk("R10 unmapped", 8'h20, 0);
  endtask

  task automatic t_size;
    wr(8'h00, 32'h10, 4'h3);
    rd_chk("R11 partial write ignored", 8'h00, 0);
    rd_chk("R11 partial read zero", 8'hC4, 0, 4'h3);
    rd_chk("R11 full read", 8'hC4, 32'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pending();
    t_priority();
    t_force();
    t_fanout();
    t_ack();
    t_race();
    t_fields();
    t_size();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule